// File: doc/BRIEF.md
# Thermal stage alarm controller

This block watches a digitized die temperature and sorts it into one of four thermal stages: normal, warning, shutdown and emergency. Three trip points set the boundaries between the stages. They sit 20 °C apart and move together in 5 °C steps under a 2-bit selector. With the selector at 0 the trip points are 105, 125 and 145 °C. With the selector at 3 they are 120, 140 and 160 °C. The temperature is sampled at one of two programmable rates. The decoded stage drives three outputs: a warning level, a sticky partial-shutdown request and a sticky emergency power-kill request. Every change of stage, upward or downward, raises a pending interrupt.

Software uses a small register file. Through it, software enables the monitor, picks the rate and the trip-point set, and may veto the partial shutdown so the operating system can power down by itself at stage 2. The emergency kill at stage 3 cannot be vetoed. The stage machine has four named states: `ST_NORMAL`, `ST_WARN`, `ST_SHUTDN` and `ST_EMERG`. On each sample, a rise transition moves it to the highest state whose trip point is reached. This can skip states. On each sample, a fall transition drops it below a state only once the temperature is more than 2 °C under that state's trip point. Between samples the state holds.

Top module: `thermal_stage_alarm`

## Requirements
- R1: After reset every register reads 0, the stage is 0, the monitor is disabled and all four outputs are low.
- R2: With selector `s` (control bits 1:0), the stage 1, 2 and 3 trip points are 105+5s, 125+5s and 145+5s °C. On a sample the stage rises to the highest stage whose trip point is at or below the temperature.
- R3: On a sample, a stage k that is already held is kept while the temperature is at least (its trip point − 2) °C. It is left once the temperature falls below that.
- R4: While enabled, a sample is taken every FAST_DIV clocks when control bit 3 is set and every SLOW_DIV clocks when it is clear. The stage changes only on a sample.
- R5: With alarm control bit 7 clear, no sample is taken. The stage is frozen and no interrupt is raised, whatever the temperature.
- R6: Status bit 0 is set by any stage change, rising or falling. It is cleared by writing 1 to it, and a new change in the same cycle wins over the clear. `irq_o` equals this bit.
- R7: `warn_o` is high exactly while the stage is 1 or higher.
- R8: A sample that yields stage 2 or 3 while control bit 6 is clear sets `part_shdn_o`, which then stays high until reset. With bit 6 set, such a sample does not set it.
- R9: A sample that yields stage 3 sets `emerg_kill_o` whatever control bit 6 holds, and it stays high until reset.
- R10: Register map: address 0 is status (bits 6:4 the stage, bit 0 pending). Address 1 is shutdown control; only bits 6, 3 and 1:0 are stored and other bits read 0. Address 2 is alarm control; only bit 7 is stored. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| temp_c | input | TW | Signed die temperature in whole °C |
| reg_addr | input | 2 | Register address for read and write |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed register (combinational) |
| warn_o | output | 1 | Warning level, stage ≥ 1 |
| part_shdn_o | output | 1 | Sticky partial-shutdown request |
| emerg_kill_o | output | 1 | Sticky emergency power-kill request |
| irq_o | output | 1 | Pending stage-change interrupt |

## Verification
The bench probes the hysteresis edge at 124, 123 and 122 °C with the selector at 0. A design that compared against the raw trip point on the way down would drop to stage 1 at 124 and fire extra interrupts. It moves the selector to 3 and puts 139 and 140 °C on either side of the shifted stage 2 trip point. A wrong step or a wrong base would place the stage off by one. It applies 200 °C with the monitor disabled and checks that no stage, interrupt or kill appears. It jumps from stage 0 straight to stage 3 to catch a machine that climbs only one stage per sample. It also runs both sample rates and checks that the shutdown veto blocks the partial request but never the emergency kill.

// File: rtl/tsa_pkg.sv
package tsa_pkg;
    typedef enum logic [1:0] {
        ST_NORMAL = 2'd0,
        ST_WARN   = 2'd1,
        ST_SHUTDN = 2'd2,
        ST_EMERG  = 2'd3
    } tstage_e;

    localparam logic [1:0] A_STATUS = 2'd0;
    localparam logic [1:0] A_SDCTL  = 2'd1;
    localparam logic [1:0] A_ALMCTL = 2'd2;

    localparam int B_PEND  = 0;
    localparam int B_RATE  = 3;
    localparam int B_VETO  = 6;
    localparam int B_EN    = 7;

    localparam logic [7:0] SDCTL_MASK  = 8'h4B;
    localparam logic [7:0] ALMCTL_MASK = 8'h80;
endpackage

// File: rtl/tsa_rate_tick.sv
module tsa_rate_tick #(
    parameter int FAST_DIV = 8,   // clocks per sample, fast rate, at least 2
    parameter int SLOW_DIV = 32   // clocks per sample, slow rate, at least 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic fast,
    output logic tick
);
    localparam int MAXD = (FAST_DIV > SLOW_DIV) ? FAST_DIV : SLOW_DIV;
    localparam int CW   = $clog2(MAXD + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim;

    assign lim  = fast ? CW'(FAST_DIV - 1) : CW'(SLOW_DIV - 1);
    assign tick = run && (cnt_q >= lim);

    always_ff @(posedge clk) begin
        if (!rst_n || !run || cnt_q >= lim) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R4
    single_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // R5
    idle_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !tick);
endmodule

// File: rtl/tsa_stage_fsm.sv
module tsa_stage_fsm
    import tsa_pkg::*;
#(
    parameter int TW    = 10,
    parameter int BASE2 = 125,  // stage 2 trip point at selector 0
    parameter int STEP  = 5,
    parameter int GAP   = 20,
    parameter int HYST  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 eval,
    input  logic signed [TW-1:0] temp,
    input  logic [1:0]           sel,
    output tstage_e              stage,
    output tstage_e              stage_nxt,
    output logic                 changed,
    output logic                 warn
);
    tstage_e state_q;
    tstage_e dec;
    int      t2;
    int      tv;
    int      lim;
    int      hits;

    // each trip point already held is lowered by the hysteresis
    always_comb begin
        t2   = BASE2 + STEP * int'(sel);
        tv   = int'(temp);
        hits = 0;
        lim  = 0;
        for (int k = 1; k <= 3; k++) begin
            lim = t2 + (k - 2) * GAP;
            if (k <= int'(state_q)) begin
                lim = lim - HYST;
            end
            if (tv >= lim) begin
                hits = hits + 1;
            end
        end
        dec = tstage_e'(hits[1:0]);
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_NORMAL;
        end else if (eval) begin
            state_q <= dec;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_NORMAL: warn = 1'b0;
            ST_WARN,
            ST_SHUTDN,
            ST_EMERG:  warn = 1'b1;
            default:   warn = 1'b0;
        endcase
    end

    assign stage     = state_q;
    assign stage_nxt = dec;
    assign changed   = eval && (dec != state_q);

    // R4
    stage_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !eval |=> $stable(state_q));

    // R6
    change_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        changed |=> (state_q != $past(state_q)));
endmodule

// File: rtl/thermal_stage_alarm.sv
module thermal_stage_alarm
    import tsa_pkg::*;
#(
    parameter int TW       = 10,
    parameter int FAST_DIV = 8,
    parameter int SLOW_DIV = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [TW-1:0] temp_c,
    input  logic [1:0]           reg_addr,
    input  logic                 reg_wr,
    input  logic [7:0]           reg_wdata,
    output logic [7:0]           reg_rdata,
    output logic                 warn_o,
    output logic                 part_shdn_o,
    output logic                 emerg_kill_o,
    output logic                 irq_o
);
    logic [7:0] sd_q;
    logic [7:0] alm_q;
    logic       pend_q;
    logic       shdn_q;
    logic       emerg_q;
    logic       tick;
    logic       chg;
    tstage_e    stage;
    tstage_e    stage_nxt;

    tsa_rate_tick #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (alm_q[B_EN]),
        .fast (sd_q[B_RATE]),
        .tick (tick)
    );

    tsa_stage_fsm #(.TW(TW)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .eval     (tick),
        .temp     (temp_c),
        .sel      (sd_q[1:0]),
        .stage    (stage),
        .stage_nxt(stage_nxt),
        .changed  (chg),
        .warn     (warn_o)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sd_q    <= '0;
            alm_q   <= '0;
            pend_q  <= 1'b0;
            shdn_q  <= 1'b0;
            emerg_q <= 1'b0;
        end else begin
            if (reg_wr && reg_addr == A_SDCTL) begin
                sd_q <= reg_wdata & SDCTL_MASK;
            end
            if (reg_wr && reg_addr == A_ALMCTL) begin
                alm_q <= reg_wdata & ALMCTL_MASK;
            end
            if (chg) begin
                pend_q <= 1'b1;
            end else if (reg_wr && reg_addr == A_STATUS && reg_wdata[B_PEND]) begin
                pend_q <= 1'b0;
            end
            if (tick && stage_nxt >= ST_SHUTDN && !sd_q[B_VETO]) begin
                shdn_q <= 1'b1;
            end
            if (tick && stage_nxt == ST_EMERG) begin
                emerg_q <= 1'b1;
            end
        end
    end

    always_comb begin
        case (reg_addr)
            A_STATUS: reg_rdata = {1'b0, 1'b0, stage, 3'b000, pend_q};
            A_SDCTL:  reg_rdata = sd_q;
            A_ALMCTL: reg_rdata = alm_q;
            default:  reg_rdata = 8'h00;
        endcase
    end

    assign part_shdn_o  = shdn_q;
    assign emerg_kill_o = emerg_q;
    assign irq_o        = pend_q;

    // R6
    irq_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chg |=> pend_q);

    // R8
    shdn_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shdn_q |=> shdn_q);

    // R8
    shdn_veto_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shdn_q) |-> (!$past(sd_q[B_VETO]) && stage >= ST_SHUTDN));

    // R9
    emerg_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        emerg_q |=> emerg_q);

    // R9
    emerg_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stage == ST_EMERG) |-> emerg_q);
endmodule

// File: tb/test_thermal_stage_alarm.sv
`timescale 1ns/1ps
module test_thermal_stage_alarm;
    localparam int TW   = 10;
    localparam int FAST = 4;
    localparam int SLOW = 12;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic signed [TW-1:0] temp_c = '0;
    logic [1:0]           reg_addr = 2'd0;
    logic                 reg_wr = 1'b0;
    logic [7:0]           reg_wdata = 8'h00;
    logic [7:0]           reg_rdata;
    logic                 warn_o, part_shdn_o, emerg_kill_o, irq_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // reference model state
    int m_cnt = 0, m_stage = 0, m_pend = 0, m_shdn = 0, m_emerg = 0;
    int m_sd = 0, m_alm = 0;

    always #2.5 clk = ~clk;

    thermal_stage_alarm #(.TW(TW), .FAST_DIV(FAST), .SLOW_DIV(SLOW)) i_thermal_stage_alarm (
        .clk(clk), .rst_n(rst_n), .temp_c(temp_c), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .warn_o(warn_o), .part_shdn_o(part_shdn_o),
        .emerg_kill_o(emerg_kill_o), .irq_o(irq_o)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_stage = 0; m_pend = 0; m_shdn = 0; m_emerg = 0;
            m_sd = 0; m_alm = 0;
        end else begin
            int per, ns, t2, thr;
            bit smp, moved;
            smp = 0; moved = 0;
            per = ((m_sd >> 3) & 1) != 0 ? FAST : SLOW;
            if ((m_alm & 8'h80) != 0) begin
                if (m_cnt >= per - 1) begin smp = 1; m_cnt = 0; end
                else m_cnt = m_cnt + 1;
            end else begin
                m_cnt = 0;
            end
            if (smp) begin
                t2 = 125 + 5 * (m_sd & 3);
                ns = 0;
                for (int k = 1; k <= 3; k++) begin
                    thr = t2 + 20 * (k - 2);
                    if (k <= m_stage) thr = thr - 2;
                    if (int'(temp_c) >= thr) ns = k;
                end
                moved = (ns != m_stage);
                if (ns >= 2 && ((m_sd >> 6) & 1) == 0) m_shdn = 1;
                if (ns == 3) m_emerg = 1;
                m_stage = ns;
            end
            if (reg_wr) begin
                case (reg_addr)
                    2'd0: if (reg_wdata[0]) m_pend = 0;
                    2'd1: m_sd  = int'(reg_wdata) & 8'h4B;
                    2'd2: m_alm = int'(reg_wdata) & 8'h80;
                    default: ;
                endcase
            end
            if (moved) m_pend = 1;
        end
    end

    function automatic int exp_rdata(input logic [1:0] a);
        case (a)
            2'd0: return (m_stage << 4) | m_pend;
            2'd1: return m_sd;
            2'd2: return m_alm;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (!done) begin
            chk("R7 warn", int'(warn_o), (m_stage >= 1) ? 1 : 0);
            chk("R8 part_shdn", int'(part_shdn_o), m_shdn);
            chk("R9 emerg_kill", int'(emerg_kill_o), m_emerg);
            chk("R6 irq", int'(irq_o), m_pend);
            chk("R10 rdata", int'(reg_rdata), exp_rdata(reg_addr));
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        step(1);
        reg_wr = 1'b0; reg_wdata = 8'h00; reg_addr = 2'd0;
    endtask

    task automatic expect_reg(input logic [1:0] a, input int exp, input string tag);
        reg_addr = a;
        #0.5;
        chk(tag, int'(reg_rdata), exp);
        reg_addr = 2'd0;
    endtask

    task automatic settle(input int t);
        temp_c = TW'(t);
        step(3 * SLOW);
    endtask

    initial begin
        step(4);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        expect_reg(2'd0, 0, "R1 status");
        expect_reg(2'd1, 0, "R1 sdctl");
        expect_reg(2'd2, 0, "R1 almctl");
        chk("R1 outputs", int'({warn_o, part_shdn_o, emerg_kill_o, irq_o}), 0);

        // R10 masking and unmapped address
        wr(2'd1, 8'hFF);
        expect_reg(2'd1, 8'h4B, "R10 sdctl mask");
        wr(2'd3, 8'hFF);
        expect_reg(2'd3, 0, "R10 addr3");

        // slow rate, veto set, selector 0
        wr(2'd1, 8'h40);
        temp_c = TW'(110);
        wr(2'd2, 8'h80);
        step(SLOW + 2);
        expect_reg(2'd0, 8'h11, "R2 R4 stage1 at 110");
        wr(2'd0, 8'h01);
        expect_reg(2'd0, 8'h10, "R6 w1c");
        settle(125);
        expect_reg(2'd0, 8'h21, "R2 stage2 at 125");
        chk("R8 veto blocks", int'(part_shdn_o), 0);
        wr(2'd0, 8'h01);
        settle(124);
        expect_reg(2'd0, 8'h20, "R3 hold at 124");
        settle(123);
        expect_reg(2'd0, 8'h20, "R3 hold at 123");
        settle(122);
        expect_reg(2'd0, 8'h11, "R3 R6 fall at 122");
        wr(2'd0, 8'h01);
        settle(80);
        expect_reg(2'd0, 8'h01, "R6 fall to 0");
        wr(2'd0, 8'h01);

        // fast rate, selector 3
        wr(2'd1, 8'h4B);
        settle(139);
        expect_reg(2'd0, 8'h11, "R2 sel3 139");
        wr(2'd0, 8'h01);
        settle(140);
        expect_reg(2'd0, 8'h21, "R2 sel3 140");
        wr(2'd0, 8'h01);

        // disabled monitor ignores temperature
        wr(2'd2, 8'h00);
        settle(200);
        expect_reg(2'd0, 8'h20, "R5 frozen");
        chk("R5 no kill", int'(emerg_kill_o), 0);
        chk("R5 no irq", int'(irq_o), 0);

        // veto cleared: partial shutdown, then emergency
        temp_c = TW'(141);
        wr(2'd1, 8'h0B);
        wr(2'd2, 8'h80);
        step(FAST + 2);
        chk("R8 part_shdn set", int'(part_shdn_o), 1);
        settle(0);
        chk("R8 part_shdn sticky", int'(part_shdn_o), 1);
        wr(2'd0, 8'h01);
        wr(2'd1, 8'h4B);
        settle(160);
        expect_reg(2'd0, 8'h31, "R2 jump 0 to 3");
        chk("R9 kill despite veto", int'(emerg_kill_o), 1);
        settle(20);
        chk("R9 kill sticky", int'(emerg_kill_o), 1);

        step(2);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule